// File: doc/BRIEF.md
# Three-Bit Up/Down Counter with Wrap or Clamp Policy

This block is a small synchronous counter whose value runs over 0 to 7. Two control lines are sampled on every rising clock edge. The first control sets the direction of the next step. The second control sets what happens at the ends of the range: the count either rolls over to the far end, or stops at the end it has reached.

Either control may change on any cycle. The counter does not restart when a control changes. It applies the new rule to the value it holds at that moment.

The counter is used where a bounded index or level must move one step per clock, for example a pointer that loops around a buffer, or a credit level that must not pass its limits. The width is a parameter with a default of 3.

The reset input is asynchronous and active low. It clears the count at once. Its release passes through a two-stage synchronizer, so counting begins two rising edges after the reset input goes high.

Top module: `updn_ctr`

## Requirements
- R1: While reset is active, the count is 0. The count stays at 0 until the synchronized release has taken effect.
- R2: Counting up in wrap mode (dir_dn=0, sat_mode=0) adds one to the count on each clock. From 7 the count goes to 0.
- R3: Counting down in wrap mode (dir_dn=1, sat_mode=0) subtracts one from the count on each clock. From 0 the count goes to 7.
- R4: Counting up in clamp mode (dir_dn=0, sat_mode=1) adds one below 7. Once the count is 7 it stays at 7.
- R5: Counting down in clamp mode (dir_dn=1, sat_mode=1) subtracts one above 0. Once the count is 0 it stays at 0.
- R6: A change of either control takes effect at the next clock, starting from the present count. If the direction reverses while the count is held at an end in clamp mode, the count leaves that end on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| dir_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| sat_mode | input | 1 | End-of-range policy: 0 wraps around, 1 clamps at the end |
| count | output | 3 | Present count value |

## Verification
A fixed sequence of vectors climbs from 0 to 7 in clamp mode and presses against 7 for several cycles. It then reverses while held at 7, switches to wrap mode exactly at 7, and rolls from 0 down to 7. After that it descends in clamp mode to 0, holds there, and reverses from 0. This sequence separates roll-over from clamping and shows whether a held end is released correctly.

A long run with random controls is then compared against an arithmetic model in the bench. Because the controls change at arbitrary values and often at both ends, this run exposes any step that depends on earlier control history rather than on the present count.

A reset applied in the middle of counting shows that clearing is immediate and that counting restarts only after the synchronized release.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;

  typedef enum logic {
    POL_WRAP  = 1'b0,
    POL_CLAMP = 1'b1
  } pol_e;
endpackage

// File: rtl/updn_rst_sync.sv
module updn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/updn_toggle_gen.sv
// Per-bit toggle mask. The least significant bit toggles on every step.
// A higher bit toggles when all bits below it are 1 (counting up)
// or all bits below it are 0 (counting down).
module updn_toggle_gen
  import updn_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur,
  input  dir_e             dir,
  output logic [WIDTH-1:0] tmask
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign tmask[i] = 1'b1;
    end else begin : g_upper
      assign tmask[i] = (dir == DIR_UP) ? (&cur[i-1:0]) : ~(|cur[i-1:0]);
    end
  end
endmodule

// File: rtl/updn_limit.sv
// Decides whether the counter must hold because it is clamped at an end.
module updn_limit
  import updn_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur,
  input  dir_e             dir,
  input  pol_e             pol,
  output logic             hold
);
  logic at_top;
  logic at_bot;

  assign at_top = &cur;
  assign at_bot = ~(|cur);

  always_comb begin
    hold = 1'b0;
    if (pol == POL_CLAMP) begin
      hold = (dir == DIR_UP) ? at_top : at_bot;
    end
  end
endmodule

// File: rtl/updn_ctr.sv
module updn_ctr
  import updn_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_dn,
  input  logic             sat_mode,
  output logic [WIDTH-1:0] count
);
  logic             rst_sync_n;
  dir_e             dir;
  pol_e             pol;
  logic [WIDTH-1:0] tmask;
  logic             hold;
  logic             cnt_en;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  assign dir = dir_e'(dir_dn);
  assign pol = pol_e'(sat_mode);

  updn_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  updn_toggle_gen #(.WIDTH(WIDTH)) i_toggle (
    .cur   (cnt_q),
    .dir   (dir),
    .tmask (tmask)
  );

  updn_limit #(.WIDTH(WIDTH)) i_limit (
    .cur  (cnt_q),
    .dir  (dir),
    .pol  (pol),
    .hold (hold)
  );

  // Next-state logic
  always_comb begin
    cnt_en = ~hold;
    cnt_d  = cnt_q ^ tmask;
  end

  // State register with explicit clock enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/updn_ctr_chk.sv
module updn_ctr_chk #(
  parameter int WIDTH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_dn,
  input logic             sat_mode,
  input logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_ZERO: assert (count == '0); // R1
    end
  end

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_dn && !sat_mode) |=> (count == $past(count) + ONE)); // R2

  AST_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_dn && !sat_mode) |=> (count == $past(count) - ONE)); // R3

  AST_CLAMP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_dn && sat_mode) |=> (count == (($past(count) == MAXV) ? MAXV : $past(count) + ONE))); // R4

  AST_CLAMP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_dn && sat_mode) |=> (count == (($past(count) == '0) ? '0 : $past(count) - ONE))); // R5

  AST_LEAVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_dn && count == MAXV) |=> (count == MAXV - ONE)); // R6

  AST_LEAVE_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_dn && count == '0) |=> (count == ONE)); // R6
endmodule

bind updn_ctr updn_ctr_chk #(.WIDTH(WIDTH)) i_updn_ctr_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .dir_dn   (dir_dn),
  .sat_mode (sat_mode),
  .count    (count)
);

// File: tb/test_updn_ctr.sv
module test_updn_ctr;
  logic       clk;
  logic       rst_n;
  logic       dir_dn;
  logic       sat_mode;
  logic [2:0] count;

  int n_cmp;
  int n_bad;

  // Each entry: {dir_dn, sat_mode, expected count after the clock}
  localparam int NV = 24;
  localparam logic [4:0] VEC [NV] = '{
    {2'b00, 3'd1}, {2'b00, 3'd2}, {2'b01, 3'd3}, {2'b01, 3'd4},
    {2'b01, 3'd5}, {2'b01, 3'd6}, {2'b01, 3'd7}, {2'b01, 3'd7},
    {2'b01, 3'd7}, {2'b11, 3'd6}, {2'b01, 3'd7}, {2'b00, 3'd0},
    {2'b10, 3'd7}, {2'b10, 3'd6}, {2'b11, 3'd5}, {2'b11, 3'd4},
    {2'b11, 3'd3}, {2'b11, 3'd2}, {2'b11, 3'd1}, {2'b11, 3'd0},
    {2'b11, 3'd0}, {2'b01, 3'd1}, {2'b11, 3'd0}, {2'b10, 3'd7}
  };

  updn_ctr i_updn_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_dn   (dir_dn),
    .sat_mode (sat_mode),
    .count    (count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [2:0] exp);
    n_cmp++;
    if (count !== exp) begin
      n_bad++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
    end
  endtask

  function automatic string req_of(input logic d, input logic m);
    if (!m) return d ? "R3" : "R2";
    return d ? "R5" : "R4";
  endfunction

  function automatic logic [2:0] model(input logic [2:0] c, input logic d, input logic m);
    if (!d) return (m && c == 3'd7) ? c : c + 3'd1;
    return (m && c == 3'd0) ? c : c - 3'd1;
  endfunction

  task automatic step(input logic d, input logic m);
    @(negedge clk);
    dir_dn   = d;
    sat_mode = m;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    dir_dn   = 1'b1;
    sat_mode = 1'b1;
    #1;
    check("R1", 3'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1", 3'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [2:0] exp;
    logic       pd;
    logic       pm;

    n_cmp    = 0;
    n_bad    = 0;
    rst_n    = 1'b0;
    dir_dn   = 1'b1;
    sat_mode = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 3'd0);
    do_reset();

    // Vector table walk
    pd = 1'b1;
    pm = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3]);
      check(req_of(VEC[i][4], VEC[i][3]), VEC[i][2:0]);
      if (VEC[i][4] != pd || VEC[i][3] != pm) check("R6", VEC[i][2:0]);
      pd = VEC[i][4];
      pm = VEC[i][3];
    end

    // Mid-count reset: clearing is immediate, counting resumes after release
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    do_reset();
    step(1'b0, 1'b0);
    check("R2", 3'd1);

    // Random control sequence against the model, with steering toward both ends
    exp = 3'd1;
    for (int i = 0; i < 3000; i++) begin
      logic d;
      logic m;
      d = $urandom_range(0, 1);
      m = $urandom_range(0, 1);
      if ((i % 40) < 12) begin
        d = (i % 80) < 40;
        m = 1'b1;
      end
      exp = model(exp, d, m);
      step(d, m);
      check("R6", exp);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule